// File: doc/BRIEF.md
# Ethernet PHY Mode Control Register

This block is the 16-bit mode control word that lives at address 0 of an Ethernet PHY's management register space. A management agent reads and writes it through a plain register port: a 5-bit address, a write strobe, 16 bits of write data and combinational read data. The block turns the stored word into the control levels the rest of the PHY uses. These are the effective link speed and duplex, loopback, isolation from the MII data path, power down and auto-negotiation enable.

Two bits of the word are commands rather than settings. One starts a soft reset and the other restarts auto-negotiation. Each command sends a one-cycle start pulse to the process it drives. The bit then reads back as 1 until that process returns a handshake, after which the bit clears by itself. Speed, duplex and auto-negotiation enable take their power-on values from three strap inputs, and a completed soft reset loads them again. Power down is the OR of a software bit and an active-low pin. While the pin is low it also sets the stored bit. When auto-negotiation is on, the effective speed and duplex come from the result inputs of the negotiation engine. When it is off, they come from the manual bits.

Top module: `phy_mode_ctl`

## Requirements
- R1: On hardware reset (rstN low at a clock edge) the word reads back with bit 13 = strapSpeed100, bit 12 = strapAnEn, bit 8 = strapFullDuplex and every other bit 0, and neither start pulse is active.
- R2: Reading address 0 returns the word, with bits 7 to 0 always 0. Any other address reads 0. A write to any other address changes nothing, and a write of any value to bits 7 to 0 has no effect.
- R3: A write to address 0 loads bits 14 (loopback), 13 (speed, 1 = 100 Mb/s), 12 (auto-negotiation enable), 11 (power down), 10 (isolate) and 8 (duplex, 1 = full). The new value is visible from the clock edge that takes the write.
- R4: Writing 1 to bit 15 sets it from the next edge and raises swRstStart for exactly that one cycle. Writing 1 again while it is set gives no further pulse. Writing 0 does not clear it.
- R5: With bit 15 set, a cycle with swRstDone high returns the whole word to the R1 values, using the strap inputs present at that moment. Any write in that same cycle is discarded.
- R6: Writing 1 to bit 9 while the stored bit 12 (the value before the write) is 1 sets bit 9 and gives a one-cycle anRestartStart pulse. Bit 9 stays 1 until a cycle with anStarted high. A write of 1 while bit 12 is stored 0 is ignored. Writing 0, or writing 1 again, neither cancels the pending restart nor pulses.
- R7: A single write that sets both bit 15 and bit 9 starts only the soft reset. Bit 9 stays 0 and anRestartStart stays low.
- R8: While bit 12 is 1, effSpeed100 and effFullDuplex follow anSpeed100 and anFullDuplex. While bit 12 is 0, they follow bits 13 and 8.
- R9: powerDown is bit 11 OR NOT pdPinN, and bit 11 reads 1 while pdPinN is 0. A low pdPinN at an edge sets the stored bit 11, which stays 1 after the pin is released until software writes 0 to it.
- R10: loopbackEn, isolateEn and anEnable are bits 14, 10 and 12 of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low hardware reset |
| regAddr | input | 5 | Register address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for the addressed register |
| strapSpeed100 | input | 1 | Power-on default for the speed bit |
| strapAnEn | input | 1 | Power-on default for auto-negotiation enable |
| strapFullDuplex | input | 1 | Power-on default for the duplex bit |
| pdPinN | input | 1 | Active-low external power-down pin |
| swRstDone | input | 1 | Soft reset process has finished |
| anStarted | input | 1 | Negotiation engine has started a restart |
| anSpeed100 | input | 1 | Negotiated speed result |
| anFullDuplex | input | 1 | Negotiated duplex result |
| swRstStart | output | 1 | One-cycle soft reset start pulse |
| anRestartStart | output | 1 | One-cycle negotiation restart pulse |
| effSpeed100 | output | 1 | Effective speed, 1 = 100 Mb/s |
| effFullDuplex | output | 1 | Effective duplex, 1 = full |
| loopbackEn | output | 1 | Loopback control |
| isolateEn | output | 1 | MII data isolation control |
| powerDown | output | 1 | Effective power down |
| anEnable | output | 1 | Auto-negotiation enable |

## Verification
The assertions assume that swRstDone and anStarted are handshakes that arrive only after the matching start pulse. They also assume that the result inputs of the negotiation engine are meaningful whenever auto-negotiation is enabled. The bench raises each handshake for a single cycle and only while the matching command bit reads back as set. It changes the straps and the negotiation results only between clock edges, away from the writes under test. Sweeps cover all strap combinations, all 64 patterns of the writable fields against all four negotiation result pairs, and every non-zero address.

// File: rtl/phy_mode_pkg.sv
package phy_mode_pkg;

  localparam int DATA_W    = 16;
  localparam int BIT_RST   = 15;
  localparam int BIT_LOOP  = 14;
  localparam int BIT_SPEED = 13;
  localparam int BIT_ANEN  = 12;
  localparam int BIT_PD    = 11;
  localparam int BIT_ISO   = 10;
  localparam int BIT_ANRS  = 9;
  localparam int BIT_DUP   = 8;

  localparam logic [DATA_W-1:0] WR_MASK =
    (DATA_W'(1) << BIT_LOOP) | (DATA_W'(1) << BIT_SPEED) | (DATA_W'(1) << BIT_ANEN) |
    (DATA_W'(1) << BIT_PD)   | (DATA_W'(1) << BIT_ISO)   | (DATA_W'(1) << BIT_DUP);

  typedef struct packed {
    logic wrFields;
    logic setRst;
    logic setAn;
    logic finishRst;
    logic finishAn;
  } modeStrobes_t;

  function automatic logic [DATA_W-1:0] defaultWord(input logic spd, input logic an,
                                                    input logic dup);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BIT_SPEED] = spd;
    w[BIT_ANEN]  = an;
    w[BIT_DUP]   = dup;
    return w;
  endfunction

endpackage

// File: rtl/phy_mode_ctrl.sv
module phy_mode_ctrl
  import phy_mode_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int MY_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              wrRstBit,
  input  logic              wrAnBit,
  input  logic              rstPending,
  input  logic              anPending,
  input  logic              anEnStored,
  input  logic              swRstDone,
  input  logic              anStarted,
  output logic              rdSel,
  output modeStrobes_t      stb,
  output logic              swRstStart,
  output logic              anRestartStart
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(MY_ADDR);

  logic wrHit;

  always_comb begin
    rdSel         = (regAddr == HIT_ADDR);
    wrHit         = regWrEn && rdSel;
    stb.finishRst = rstPending && swRstDone;
    stb.finishAn  = anPending && anStarted;
    stb.wrFields  = wrHit && !stb.finishRst;
    stb.setRst    = wrHit && wrRstBit && !rstPending;
    // a reset request in the same write wins over the restart
    stb.setAn     = wrHit && wrAnBit && !wrRstBit && anEnStored && !anPending
                    && !stb.finishRst;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swRstStart     <= 1'b0;
      anRestartStart <= 1'b0;
    end else begin
      swRstStart     <= stb.setRst;
      anRestartStart <= stb.setAn;
    end
  end

endmodule

// File: rtl/phy_mode_dp.sv
module phy_mode_dp
  import phy_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  modeStrobes_t      stb,
  input  logic              rdSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              strapSpeed100,
  input  logic              strapAnEn,
  input  logic              strapFullDuplex,
  input  logic              pdPinN,
  input  logic              anSpeed100,
  input  logic              anFullDuplex,
  output logic [DATA_W-1:0] regRdData,
  output logic              rstPending,
  output logic              anPending,
  output logic              anEnStored,
  output logic              effSpeed100,
  output logic              effFullDuplex,
  output logic              loopbackEn,
  output logic              isolateEn,
  output logic              powerDown
);

  logic [DATA_W-1:0] ctlWord;
  logic [DATA_W-1:0] nextWord;
  logic [DATA_W-1:0] viewWord;

  always_comb begin
    nextWord = ctlWord;
    if (stb.finishRst) begin
      nextWord = defaultWord(strapSpeed100, strapAnEn, strapFullDuplex);
    end else begin
      if (stb.wrFields) nextWord = (ctlWord & ~WR_MASK) | (regWrData & WR_MASK);
      if (stb.setRst) nextWord[BIT_RST] = 1'b1;
      if (stb.setAn) nextWord[BIT_ANRS] = 1'b1;
      else if (stb.finishAn) nextWord[BIT_ANRS] = 1'b0;
    end
    if (!pdPinN) nextWord[BIT_PD] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctlWord <= defaultWord(strapSpeed100, strapAnEn, strapFullDuplex);
    else       ctlWord <= nextWord;
  end

  always_comb begin
    viewWord         = ctlWord;
    viewWord[BIT_PD] = ctlWord[BIT_PD] | ~pdPinN;
    regRdData        = rdSel ? viewWord : '0;
    rstPending       = ctlWord[BIT_RST];
    anPending        = ctlWord[BIT_ANRS];
    anEnStored       = ctlWord[BIT_ANEN];
    effSpeed100      = ctlWord[BIT_ANEN] ? anSpeed100   : ctlWord[BIT_SPEED];
    effFullDuplex    = ctlWord[BIT_ANEN] ? anFullDuplex : ctlWord[BIT_DUP];
    loopbackEn       = ctlWord[BIT_LOOP];
    isolateEn        = ctlWord[BIT_ISO];
    powerDown        = viewWord[BIT_PD];
  end

endmodule

// File: rtl/phy_mode_ctl.sv
module phy_mode_ctl
  import phy_mode_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int MY_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  input  logic              strapSpeed100,
  input  logic              strapAnEn,
  input  logic              strapFullDuplex,
  input  logic              pdPinN,
  input  logic              swRstDone,
  input  logic              anStarted,
  input  logic              anSpeed100,
  input  logic              anFullDuplex,
  output logic              swRstStart,
  output logic              anRestartStart,
  output logic              effSpeed100,
  output logic              effFullDuplex,
  output logic              loopbackEn,
  output logic              isolateEn,
  output logic              powerDown,
  output logic              anEnable
);

  modeStrobes_t stb;
  logic rdSel, rstPending, anPending, anEnStored;

  phy_mode_ctrl #(.ADDR_W(ADDR_W), .MY_ADDR(MY_ADDR)) ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .wrRstBit(regWrData[BIT_RST]), .wrAnBit(regWrData[BIT_ANRS]),
    .rstPending(rstPending), .anPending(anPending), .anEnStored(anEnStored),
    .swRstDone(swRstDone), .anStarted(anStarted), .rdSel(rdSel), .stb(stb),
    .swRstStart(swRstStart), .anRestartStart(anRestartStart)
  );

  phy_mode_dp dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .regWrData(regWrData),
    .strapSpeed100(strapSpeed100), .strapAnEn(strapAnEn),
    .strapFullDuplex(strapFullDuplex), .pdPinN(pdPinN),
    .anSpeed100(anSpeed100), .anFullDuplex(anFullDuplex),
    .regRdData(regRdData), .rstPending(rstPending), .anPending(anPending),
    .anEnStored(anEnStored), .effSpeed100(effSpeed100),
    .effFullDuplex(effFullDuplex), .loopbackEn(loopbackEn),
    .isolateEn(isolateEn), .powerDown(powerDown)
  );

  assign anEnable = anEnStored;

endmodule

// File: rtl/phy_mode_chk.sv
module phy_mode_chk #(
  parameter int ADDR_W  = 5,
  parameter int MY_ADDR = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic [15:0]       regRdData,
  input logic              pdPinN,
  input logic              powerDown,
  input logic              anEnable,
  input logic              effSpeed100,
  input logic              effFullDuplex,
  input logic              anSpeed100,
  input logic              anFullDuplex,
  input logic              swRstStart,
  input logic              anRestartStart,
  input logic              loopbackEn,
  input logic              isolateEn
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(MY_ADDR);

  always @(posedge clk) begin
    if (rstN) begin
      assert_reserved_zero_R2: assert (regRdData[7:0] == 8'h00);
    end
  end

  assert_other_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != HIT_ADDR) |-> (regRdData == 16'h0000));

  assert_rst_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    swRstStart |=> !swRstStart);

  assert_an_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    anRestartStart |=> !anRestartStart);

  assert_reset_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    swRstStart |-> !anRestartStart);

  assert_auto_mode_R8: assert property (@(posedge clk) disable iff (!rstN)
    anEnable |-> (effSpeed100 == anSpeed100 && effFullDuplex == anFullDuplex));

  assert_manual_mode_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!anEnable && regAddr == HIT_ADDR) |->
      (effSpeed100 == regRdData[13] && effFullDuplex == regRdData[8]));

  assert_pin_pd_R9: assert property (@(posedge clk) disable iff (!rstN)
    !pdPinN |-> powerDown);

  assert_mirror_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == HIT_ADDR) |-> (loopbackEn == regRdData[14] && isolateEn == regRdData[10]
      && anEnable == regRdData[12] && powerDown == regRdData[11]));

endmodule

bind phy_mode_ctl phy_mode_chk #(.ADDR_W(ADDR_W), .MY_ADDR(MY_ADDR)) chk (.*);

// File: tb/phy_mode_ctl_test.sv
module phy_mode_ctl_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic strapSpeed100 = 1'b0, strapAnEn = 1'b0, strapFullDuplex = 1'b0;
  logic pdPinN = 1'b1, swRstDone = 1'b0, anStarted = 1'b0;
  logic anSpeed100 = 1'b0, anFullDuplex = 1'b0;
  logic swRstStart, anRestartStart, effSpeed100, effFullDuplex;
  logic loopbackEn, isolateEn, powerDown, anEnable;

  int testCount = 0;
  int failCount = 0;

  always #5 clk = ~clk;

  phy_mode_ctl uut (.*);

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkEq(input string tag, input logic [15:0] act, input logic [15:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  task automatic doWrite(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    #1;
  endtask

  task automatic readAt(input logic [4:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic hwReset(input logic s, input logic a, input logic d);
    @(negedge clk);
    strapSpeed100 = s; strapAnEn = a; strapFullDuplex = d; rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  task automatic pulseInput(input bit isRst);
    @(negedge clk);
    if (isRst) swRstDone = 1'b1; else anStarted = 1'b1;
    @(negedge clk);
    swRstDone = 1'b0; anStarted = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [15:0] rd, exp, data;

    // R1: reset values across every strap combination
    for (int s = 0; s < 8; s++) begin
      hwReset(s[2], s[1], s[0]);
      readAt(5'd0, rd);
      exp = 16'(s[2]) << 13 | 16'(s[1]) << 12 | 16'(s[0]) << 8;
      checkEq("R1 reset word", rd, exp);
      checkEq("R1 no pulses", {14'd0, swRstStart, anRestartStart}, 16'h0);
    end

    // R3 R8 R10: all writable field patterns, all negotiation result pairs
    for (int p = 0; p < 64; p++) begin
      data = 16'(p[5]) << 14 | 16'(p[4]) << 13 | 16'(p[3]) << 12 | 16'(p[2]) << 11 |
             16'(p[1]) << 10 | 16'(p[0]) << 8 | 16'h00A5;
      doWrite(5'd0, data);
      readAt(5'd0, rd);
      checkEq("R3 field write", rd, data & 16'h7D00);
      checkEq("R2 reserved ignored", rd & 16'h00FF, 16'h0);
      for (int r = 0; r < 4; r++) begin
        anSpeed100 = r[1]; anFullDuplex = r[0];
        #1;
        exp = p[3] ? {14'd0, r[1], r[0]} : {14'd0, p[4], p[0]};
        checkEq("R8 effective speed/duplex", {14'd0, effSpeed100, effFullDuplex}, exp);
      end
      checkEq("R10 level outputs", {12'd0, loopbackEn, isolateEn, anEnable, powerDown},
              {12'd0, p[5], p[1], p[3], p[2]});
    end

    // R2: other addresses
    doWrite(5'd0, 16'h0000);
    for (int a = 1; a < 32; a++) begin
      doWrite(5'(a), 16'hFFFF);
      readAt(5'(a), rd);
      checkEq("R2 other address reads 0", rd, 16'h0);
      readAt(5'd0, rd);
      checkEq("R2 word unchanged", rd, 16'h0);
      checkEq("R2 no pulse", {14'd0, swRstStart, anRestartStart}, 16'h0);
    end

    // R9: power-down pin
    @(negedge clk); pdPinN = 1'b0; #1;
    readAt(5'd0, rd);
    checkEq("R9 pin forces pd", {rd[11], 14'd0, powerDown}, 16'h8001);
    @(negedge clk); pdPinN = 1'b1; #1;
    readAt(5'd0, rd);
    checkEq("R9 pd sticky after pin", {rd[11], 14'd0, powerDown}, 16'h8001);
    doWrite(5'd0, 16'h0000);
    readAt(5'd0, rd);
    checkEq("R9 pd cleared by write", {rd[11], 14'd0, powerDown}, 16'h0);
    @(negedge clk); pdPinN = 1'b0;
    doWrite(5'd0, 16'h0000);
    pdPinN = 1'b1; #1;
    readAt(5'd0, rd);
    checkEq("R9 pin beats write of 0", rd, 16'h0800);
    doWrite(5'd0, 16'h0000);

    // R4 R5: soft reset command
    hwReset(1'b1, 1'b0, 1'b1);
    doWrite(5'd0, 16'hC400);
    readAt(5'd0, rd);
    checkEq("R4 reset bit set", rd, 16'hC400);
    checkEq("R4 reset start pulse", {15'd0, swRstStart}, 16'h1);
    @(negedge clk); #1;
    checkEq("R4 pulse one cycle", {15'd0, swRstStart}, 16'h0);
    doWrite(5'd0, 16'h8000);
    readAt(5'd0, rd);
    checkEq("R4 no second pulse", {15'd0, swRstStart}, 16'h0);
    checkEq("R4 still pending", rd, 16'h8000);
    doWrite(5'd0, 16'h0000);
    readAt(5'd0, rd);
    checkEq("R4 write 0 keeps pending", rd, 16'h8000);
    @(negedge clk);
    strapSpeed100 = 1'b0; strapAnEn = 1'b1; strapFullDuplex = 1'b0;
    regAddr = 5'd0; regWrData = 16'h4000; regWrEn = 1'b1; swRstDone = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; swRstDone = 1'b0; #1;
    readAt(5'd0, rd);
    checkEq("R5 strap reload, write dropped", rd, 16'h1000);
    checkEq("R5 loopback off", {15'd0, loopbackEn}, 16'h0);

    // R6: negotiation restart
    doWrite(5'd0, 16'h1200);
    readAt(5'd0, rd);
    checkEq("R6 restart pending", rd, 16'h1200);
    checkEq("R6 restart pulse", {15'd0, anRestartStart}, 16'h1);
    doWrite(5'd0, 16'h1200);
    checkEq("R6 no repeat pulse", {15'd0, anRestartStart}, 16'h0);
    doWrite(5'd0, 16'h1000);
    readAt(5'd0, rd);
    checkEq("R6 write 0 no cancel", rd, 16'h1200);
    pulseInput(1'b0);
    readAt(5'd0, rd);
    checkEq("R6 self clear", rd, 16'h1000);
    doWrite(5'd0, 16'h0000);
    doWrite(5'd0, 16'h1200);
    readAt(5'd0, rd);
    checkEq("R6 ignored while an off", rd, 16'h1000);
    checkEq("R6 no pulse while an off", {15'd0, anRestartStart}, 16'h0);
    doWrite(5'd0, 16'h1200);
    checkEq("R6 pulse once enabled", {15'd0, anRestartStart}, 16'h1);
    pulseInput(1'b0);

    // R7: both commands in one write
    doWrite(5'd0, 16'h9200);
    readAt(5'd0, rd);
    checkEq("R7 reset wins", rd, 16'h9000);
    checkEq("R7 pulses", {14'd0, swRstStart, anRestartStart}, 16'h2);
    pulseInput(1'b1);
    readAt(5'd0, rd);
    checkEq("R5 reset completes", rd, 16'h1000);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule